// File: doc/BRIEF.md
# IN Endpoint Transmit Queue Control

This block holds one transmit slot per IN endpoint of a full-speed USB device and decides how each IN token is answered. Software loads an endpoint's slot with a buffer number, a byte count and a ready flag. When the host then polls that endpoint, the block either hands the buffer number and length to the packet sender, answers that nothing is queued, or signals a stall. Separate logic owns serializing, CRC and buffer memory.

The block remembers which endpoint last received data. When the host acknowledges that data, the block frees the slot and sets a per-endpoint completion bit. Software clears a completion bit by writing a one to it. The interrupt line stays high while any completion bit is set. If a SETUP token reaches a control endpoint that still has data queued, the queued data is withdrawn and marked as deferred so software can requeue it after the control transfer ends.

Top module: `usbin_txq`

## Requirements
- R1: While reset is high, every slot (buffer, length, ready, pend) clears to zero. Reset also clears every completion bit, drops the interrupt and sets the response code to 0 (none).
- R2: A software write stores the buffer number, ready flag and pend flag as given. It stores the length clamped to 64, so a write of 100 reads back as 64. The readback port shows the slot selected by `rd_ep_i`.
- R3: An IN token on a ready, unstalled endpoint gives response code 1 (data) in the cycle after the token. The response carries that slot's buffer number and length, and the ready flag stays set.
- R4: An IN token on an unstalled endpoint whose ready flag is clear gives code 2 (NAK). An IN token on a stalled endpoint gives code 3 (stall) whether or not the slot is ready. Neither changes the slot.
- R5: An ACK the cycle after a data response clears that endpoint's ready flag and sets its completion bit. An ACK is ignored when no data is outstanding: after a NAK or stall, after an earlier ACK, or after any later token.
- R6: With no ACK, a later IN token on the same endpoint returns the same buffer number and length again.
- R7: Writing ones on `sent_clr_i` clears those completion bits and leaves the others alone. `irq_o` is high exactly when at least one completion bit is set. A completion bit is only set by an ACK.
- R8: When an ACK and a clear hit the same completion bit in the same cycle, the bit ends up set.
- R9: A SETUP token on an endpoint marked control in `ctrl_ep_i` whose ready flag is set clears ready and sets pend. On a non-control endpoint, or on one with ready clear, a SETUP leaves the slot unchanged. A SETUP also cancels any outstanding data, so a following ACK is ignored.
- R10: Endpoint numbers at or above the endpoint count are inert. Writes to them are dropped, IN tokens to them give code 0, and their readback is zero.
- R11: When a software write and an ACK land on the same endpoint in the same cycle, the slot takes the written value and the completion bit is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cfg_wr_i | input | 1 | Software slot write strobe |
| cfg_ep_i | input | 4 | Endpoint number for the write |
| cfg_bid_i | input | 5 | Buffer number to store |
| cfg_len_i | input | 7 | Byte count to store (clamped to 64) |
| cfg_rdy_i | input | 1 | Ready flag to store |
| cfg_pend_i | input | 1 | Pend flag to store |
| rd_ep_i | input | 4 | Endpoint selected for readback |
| rd_bid_o | output | 5 | Readback buffer number |
| rd_len_o | output | 7 | Readback byte count |
| rd_rdy_o | output | 1 | Readback ready flag |
| rd_pend_o | output | 1 | Readback pend flag |
| sent_clr_i | input | 12 | Write-one-to-clear mask for completion bits |
| sent_o | output | 12 | Completion bits, one per endpoint |
| irq_o | output | 1 | Packet-sent interrupt |
| ctrl_ep_i | input | 12 | Marks endpoints of control type |
| stall_i | input | 12 | Per-endpoint stall flags |
| tok_in_i | input | 1 | IN token seen (one-cycle pulse) |
| tok_setup_i | input | 1 | SETUP token seen (one-cycle pulse, wins over IN) |
| tok_ep_i | input | 4 | Endpoint of the token |
| host_ack_i | input | 1 | Host handshake ACK received |
| resp_o | output | 2 | Response code: 0 none, 1 data, 2 NAK, 3 stall |
| resp_bid_o | output | 5 | Buffer number to transmit with a data response |
| resp_len_o | output | 7 | Byte count to transmit with a data response |

## Verification
Each slot's ready flag, the outstanding-data record and the completion bits all show up at the ports in the cycle after the event that updates them. A ready flag left set in error shows up at the next IN token on that endpoint, which returns data instead of NAK. A wrong outstanding-data record makes the next ACK either set the wrong completion bit or set none at all, and `sent_o` and `irq_o` show this one cycle later. A missed SETUP preemption shows up right away on the readback port as a pend flag that stays clear.

// File: rtl/usbin_pkg.sv
package usbin_pkg;

    localparam int EP_W       = 4;
    localparam int BUF_W      = 5;
    localparam int LEN_W      = 7;
    localparam int MAX_LEN    = 64;
    localparam int NUM_EP_DEF = 12;

    typedef enum logic [1:0] {
        RSP_NONE  = 2'd0,
        RSP_DATA  = 2'd1,
        RSP_NAK   = 2'd2,
        RSP_STALL = 2'd3
    } rsp_e;

    typedef struct packed {
        logic             pend;
        logic             rdy;
        logic [LEN_W-1:0] len;
        logic [BUF_W-1:0] bid;
    } ep_word_t;

    function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] raw);
        if (int'(raw) > MAX_LEN) return LEN_W'(MAX_LEN);
        return raw;
    endfunction

    function automatic ep_word_t make_word(input logic [BUF_W-1:0] bid,
                                           input logic [LEN_W-1:0] len,
                                           input logic             rdy,
                                           input logic             pend);
        ep_word_t w;
        w.bid  = bid;
        w.len  = clamp_len(len);
        w.rdy  = rdy;
        w.pend = pend;
        return w;
    endfunction

endpackage

// File: rtl/usbin_ep_regs.sv
module usbin_ep_regs
    import usbin_pkg::*;
#(
    parameter int NUM_EP = NUM_EP_DEF
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            wr_en_i,
    input  logic [EP_W-1:0] wr_ep_i,
    input  ep_word_t        wr_word_i,
    input  logic            ack_fire_i,
    input  logic [EP_W-1:0] ack_ep_i,
    input  logic            setup_fire_i,
    input  logic [EP_W-1:0] setup_ep_i,
    input  logic [NUM_EP-1:0] ctrl_ep_i,
    output ep_word_t        words_o [NUM_EP]
);

    for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
        logic wr_hit;
        logic ack_hit;
        logic setup_hit;
        ep_word_t word_q;

        assign wr_hit    = wr_en_i && (wr_ep_i == EP_W'(e));
        assign ack_hit   = ack_fire_i && (ack_ep_i == EP_W'(e));
        assign setup_hit = setup_fire_i && (setup_ep_i == EP_W'(e)) && ctrl_ep_i[e];

        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                word_q <= '0;
            end else if (wr_hit) begin
                word_q <= wr_word_i;
            end else if (ack_hit) begin
                word_q.rdy <= 1'b0;
            end else if (setup_hit && word_q.rdy) begin
                word_q.rdy  <= 1'b0;
                word_q.pend <= 1'b1;
            end
        end

        assign words_o[e] = word_q;
    end

endmodule

// File: rtl/usbin_resp.sv
module usbin_resp
    import usbin_pkg::*;
#(
    parameter int NUM_EP = NUM_EP_DEF
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              tok_in_i,
    input  logic              tok_setup_i,
    input  logic [EP_W-1:0]   tok_ep_i,
    input  ep_word_t          words_i [NUM_EP],
    input  logic [NUM_EP-1:0] stall_i,
    input  logic              host_ack_i,
    output rsp_e              resp_o,
    output logic [BUF_W-1:0]  resp_bid_o,
    output logic [LEN_W-1:0]  resp_len_o,
    output logic              ack_fire_o,
    output logic [EP_W-1:0]   ack_ep_o
);

    ep_word_t        sel_word;
    logic            sel_stall;
    logic            ep_ok;
    logic            in_ok;
    rsp_e            rsp_d;
    rsp_e            rsp_q;
    logic [BUF_W-1:0] bid_q;
    logic [LEN_W-1:0] len_q;
    logic            infl_vld_q;
    logic [EP_W-1:0] infl_ep_q;

    always_comb begin
        sel_word  = '0;
        sel_stall = 1'b0;
        for (int e = 0; e < NUM_EP; e++) begin
            if (tok_ep_i == EP_W'(e)) begin
                sel_word  = words_i[e];
                sel_stall = stall_i[e];
            end
        end
    end

    assign ep_ok = int'(tok_ep_i) < NUM_EP;
    assign in_ok = tok_in_i && !tok_setup_i && ep_ok;

    always_comb begin
        rsp_d = RSP_NONE;
        if (in_ok) begin
            if (sel_stall)         rsp_d = RSP_STALL;
            else if (sel_word.rdy) rsp_d = RSP_DATA;
            else                   rsp_d = RSP_NAK;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rsp_q <= RSP_NONE;
            bid_q <= '0;
            len_q <= '0;
        end else begin
            rsp_q <= rsp_d;
            if (rsp_d == RSP_DATA) begin
                bid_q <= sel_word.bid;
                len_q <= sel_word.len;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            infl_vld_q <= 1'b0;
            infl_ep_q  <= '0;
        end else if (tok_in_i || tok_setup_i) begin
            infl_vld_q <= (rsp_d == RSP_DATA);
            infl_ep_q  <= tok_ep_i;
        end else if (host_ack_i) begin
            infl_vld_q <= 1'b0;
        end
    end

    assign ack_fire_o = host_ack_i && infl_vld_q;
    assign ack_ep_o   = infl_ep_q;
    assign resp_o     = rsp_q;
    assign resp_bid_o = (rsp_q == RSP_DATA) ? bid_q : '0;
    assign resp_len_o = (rsp_q == RSP_DATA) ? len_q : '0;

endmodule

// File: rtl/usbin_sent.sv
module usbin_sent
    import usbin_pkg::*;
#(
    parameter int NUM_EP = NUM_EP_DEF
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [NUM_EP-1:0] set_i,
    input  logic [NUM_EP-1:0] clr_i,
    output logic [NUM_EP-1:0] sent_o,
    output logic              irq_o
);

    logic [NUM_EP-1:0] sent_q;
    logic              irq_q;
    logic [NUM_EP-1:0] sent_d;

    assign sent_d = (sent_q & ~clr_i) | set_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sent_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            sent_q <= sent_d;
            irq_q  <= |sent_d;
        end
    end

    assign sent_o = sent_q;
    assign irq_o  = irq_q;

endmodule

// File: rtl/usbin_txq.sv
module usbin_txq
    import usbin_pkg::*;
#(
    parameter int NUM_EP = NUM_EP_DEF
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              cfg_wr_i,
    input  logic [EP_W-1:0]   cfg_ep_i,
    input  logic [BUF_W-1:0]  cfg_bid_i,
    input  logic [LEN_W-1:0]  cfg_len_i,
    input  logic              cfg_rdy_i,
    input  logic              cfg_pend_i,
    input  logic [EP_W-1:0]   rd_ep_i,
    output logic [BUF_W-1:0]  rd_bid_o,
    output logic [LEN_W-1:0]  rd_len_o,
    output logic              rd_rdy_o,
    output logic              rd_pend_o,
    input  logic [NUM_EP-1:0] sent_clr_i,
    output logic [NUM_EP-1:0] sent_o,
    output logic              irq_o,
    input  logic [NUM_EP-1:0] ctrl_ep_i,
    input  logic [NUM_EP-1:0] stall_i,
    input  logic              tok_in_i,
    input  logic              tok_setup_i,
    input  logic [EP_W-1:0]   tok_ep_i,
    input  logic              host_ack_i,
    output logic [1:0]        resp_o,
    output logic [BUF_W-1:0]  resp_bid_o,
    output logic [LEN_W-1:0]  resp_len_o
);

    ep_word_t          words [NUM_EP];
    ep_word_t          wr_word;
    ep_word_t          rd_word;
    logic              ack_fire;
    logic [EP_W-1:0]   ack_ep;
    logic [NUM_EP-1:0] ack_set_vec;
    rsp_e              rsp;

    assign wr_word = make_word(cfg_bid_i, cfg_len_i, cfg_rdy_i, cfg_pend_i);

    usbin_ep_regs #(.NUM_EP(NUM_EP)) u_regs (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .wr_en_i      (cfg_wr_i),
        .wr_ep_i      (cfg_ep_i),
        .wr_word_i    (wr_word),
        .ack_fire_i   (ack_fire),
        .ack_ep_i     (ack_ep),
        .setup_fire_i (tok_setup_i),
        .setup_ep_i   (tok_ep_i),
        .ctrl_ep_i    (ctrl_ep_i),
        .words_o      (words)
    );

    usbin_resp #(.NUM_EP(NUM_EP)) u_resp (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .tok_in_i    (tok_in_i),
        .tok_setup_i (tok_setup_i),
        .tok_ep_i    (tok_ep_i),
        .words_i     (words),
        .stall_i     (stall_i),
        .host_ack_i  (host_ack_i),
        .resp_o      (rsp),
        .resp_bid_o  (resp_bid_o),
        .resp_len_o  (resp_len_o),
        .ack_fire_o  (ack_fire),
        .ack_ep_o    (ack_ep)
    );

    always_comb begin
        ack_set_vec = '0;
        for (int e = 0; e < NUM_EP; e++) begin
            if (ack_fire && ack_ep == EP_W'(e)) ack_set_vec[e] = 1'b1;
        end
    end

    usbin_sent #(.NUM_EP(NUM_EP)) u_sent (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .set_i  (ack_set_vec),
        .clr_i  (sent_clr_i),
        .sent_o (sent_o),
        .irq_o  (irq_o)
    );

    always_comb begin
        rd_word = '0;
        for (int e = 0; e < NUM_EP; e++) begin
            if (rd_ep_i == EP_W'(e)) rd_word = words[e];
        end
    end

    assign rd_bid_o  = rd_word.bid;
    assign rd_len_o  = rd_word.len;
    assign rd_rdy_o  = rd_word.rdy;
    assign rd_pend_o = rd_word.pend;
    assign resp_o    = rsp;

endmodule

// File: rtl/usbin_txq_chk.sv
module usbin_txq_chk
    import usbin_pkg::*;
#(
    parameter int NUM_EP = NUM_EP_DEF
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              tok_in_i,
    input logic              tok_setup_i,
    input logic [EP_W-1:0]   tok_ep_i,
    input logic [NUM_EP-1:0] stall_i,
    input logic [1:0]        resp_o,
    input logic [NUM_EP-1:0] sent_o,
    input logic [NUM_EP-1:0] ack_set_vec
);

    logic ep_ok;
    logic stall_sel;

    assign ep_ok = int'(tok_ep_i) < NUM_EP;

    always_comb begin
        stall_sel = 1'b0;
        for (int e = 0; e < NUM_EP; e++) begin
            if (tok_ep_i == EP_W'(e)) stall_sel = stall_i[e];
        end
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk_i)
        rst_i |=> (sent_o == '0 && resp_o == 2'd0));

    // R3
    data_needs_in_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (resp_o == 2'd1) |-> ($past(tok_in_i) && !$past(tok_setup_i)));

    // R4
    stall_wins_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (tok_in_i && !tok_setup_i && ep_ok && stall_sel) |=> (resp_o == 2'd3));

    // R10
    oor_silent_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (tok_in_i && !ep_ok) |=> (resp_o == 2'd0));

    // R8
    ack_sets_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (ack_set_vec != '0) |=> ((sent_o & $past(ack_set_vec)) == $past(ack_set_vec)));

    // R7
    sent_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (ack_set_vec == '0) |=> ((sent_o & ~$past(sent_o)) == '0));

endmodule

bind usbin_txq usbin_txq_chk #(.NUM_EP(NUM_EP)) u_chk (.*);

// File: tb/usbin_txq_bench.sv
module usbin_txq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NEP = 12;

    localparam logic [2:0] OP_WR = 3'd0, OP_IN = 3'd1, OP_ACK = 3'd2,
                           OP_SETUP = 3'd3, OP_CLR = 3'd4;

    typedef struct packed {
        logic [2:0]  op;
        logic [3:0]  ep;
        logic [4:0]  bid;
        logic [6:0]  len;
        logic        rdy;
        logic [11:0] mask;
        logic [1:0]  eresp;
        logic [4:0]  ebid;
        logic [6:0]  elen;
        logic        erdy;
        logic        epend;
        logic [11:0] esent;
    } vec_t;

    localparam int NVEC = 19;
    localparam vec_t TBL [NVEC] = '{
        '{OP_WR,    4'd2,  5'd7,  7'd20,  1'b1, 12'h000, 2'd0, 5'd7,  7'd20, 1'b1, 1'b0, 12'h000},
        '{OP_IN,    4'd2,  5'd0,  7'd0,   1'b0, 12'h000, 2'd1, 5'd7,  7'd20, 1'b1, 1'b0, 12'h000},
        '{OP_IN,    4'd2,  5'd0,  7'd0,   1'b0, 12'h000, 2'd1, 5'd7,  7'd20, 1'b1, 1'b0, 12'h000},
        '{OP_ACK,   4'd2,  5'd0,  7'd0,   1'b0, 12'h000, 2'd0, 5'd7,  7'd20, 1'b0, 1'b0, 12'h004},
        '{OP_ACK,   4'd2,  5'd0,  7'd0,   1'b0, 12'h000, 2'd0, 5'd7,  7'd20, 1'b0, 1'b0, 12'h004},
        '{OP_IN,    4'd2,  5'd0,  7'd0,   1'b0, 12'h000, 2'd2, 5'd7,  7'd20, 1'b0, 1'b0, 12'h004},
        '{OP_WR,    4'd5,  5'd31, 7'd100, 1'b1, 12'h000, 2'd0, 5'd31, 7'd64, 1'b1, 1'b0, 12'h004},
        '{OP_IN,    4'd5,  5'd0,  7'd0,   1'b0, 12'h000, 2'd1, 5'd31, 7'd64, 1'b1, 1'b0, 12'h004},
        '{OP_ACK,   4'd5,  5'd0,  7'd0,   1'b0, 12'h000, 2'd0, 5'd31, 7'd64, 1'b0, 1'b0, 12'h024},
        '{OP_CLR,   4'd5,  5'd0,  7'd0,   1'b0, 12'h004, 2'd0, 5'd31, 7'd64, 1'b0, 1'b0, 12'h020},
        '{OP_WR,    4'd0,  5'd3,  7'd8,   1'b1, 12'h000, 2'd0, 5'd3,  7'd8,  1'b1, 1'b0, 12'h020},
        '{OP_SETUP, 4'd0,  5'd0,  7'd0,   1'b0, 12'h000, 2'd0, 5'd3,  7'd8,  1'b0, 1'b1, 12'h020},
        '{OP_WR,    4'd1,  5'd4,  7'd0,   1'b1, 12'h000, 2'd0, 5'd4,  7'd0,  1'b1, 1'b0, 12'h020},
        '{OP_SETUP, 4'd1,  5'd0,  7'd0,   1'b0, 12'h000, 2'd0, 5'd4,  7'd0,  1'b1, 1'b0, 12'h020},
        '{OP_IN,    4'd1,  5'd0,  7'd0,   1'b0, 12'h000, 2'd1, 5'd4,  7'd0,  1'b1, 1'b0, 12'h020},
        '{OP_SETUP, 4'd0,  5'd0,  7'd0,   1'b0, 12'h000, 2'd0, 5'd3,  7'd8,  1'b0, 1'b1, 12'h020},
        '{OP_ACK,   4'd1,  5'd0,  7'd0,   1'b0, 12'h000, 2'd0, 5'd4,  7'd0,  1'b1, 1'b0, 12'h020},
        '{OP_IN,    4'd13, 5'd0,  7'd0,   1'b0, 12'h000, 2'd0, 5'd0,  7'd0,  1'b0, 1'b0, 12'h020},
        '{OP_WR,    4'd13, 5'd9,  7'd9,   1'b1, 12'h000, 2'd0, 5'd0,  7'd0,  1'b0, 1'b0, 12'h020}
    };

    logic            clk = 1'b0;
    logic            rst;
    logic            cfg_wr;
    logic [3:0]      cfg_ep;
    logic [4:0]      cfg_bid;
    logic [6:0]      cfg_len;
    logic            cfg_rdy;
    logic            cfg_pend;
    logic [3:0]      rd_ep;
    logic [4:0]      rd_bid;
    logic [6:0]      rd_len;
    logic            rd_rdy;
    logic            rd_pend;
    logic [NEP-1:0]  sent_clr;
    logic [NEP-1:0]  sent;
    logic            irq;
    logic [NEP-1:0]  ctrl_ep;
    logic [NEP-1:0]  stall;
    logic            tok_in;
    logic            tok_setup;
    logic [3:0]      tok_ep;
    logic            host_ack;
    logic [1:0]      resp;
    logic [4:0]      resp_bid;
    logic [6:0]      resp_len;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usbin_txq #(.NUM_EP(NEP)) u_usbin_txq (
        .clk_i(clk), .rst_i(rst),
        .cfg_wr_i(cfg_wr), .cfg_ep_i(cfg_ep), .cfg_bid_i(cfg_bid), .cfg_len_i(cfg_len),
        .cfg_rdy_i(cfg_rdy), .cfg_pend_i(cfg_pend),
        .rd_ep_i(rd_ep), .rd_bid_o(rd_bid), .rd_len_o(rd_len), .rd_rdy_o(rd_rdy),
        .rd_pend_o(rd_pend),
        .sent_clr_i(sent_clr), .sent_o(sent), .irq_o(irq),
        .ctrl_ep_i(ctrl_ep), .stall_i(stall),
        .tok_in_i(tok_in), .tok_setup_i(tok_setup), .tok_ep_i(tok_ep),
        .host_ack_i(host_ack),
        .resp_o(resp), .resp_bid_o(resp_bid), .resp_len_o(resp_len)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle();
        cfg_wr = 0; cfg_ep = 0; cfg_bid = 0; cfg_len = 0; cfg_rdy = 0; cfg_pend = 0;
        sent_clr = '0; tok_in = 0; tok_setup = 0; tok_ep = 0; host_ack = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic wr(input int ep, input int bid, input int len, input bit r);
        cfg_wr = 1; cfg_ep = 4'(ep); cfg_bid = 5'(bid); cfg_len = 7'(len); cfg_rdy = r;
        tick();
    endtask

    task automatic in_tok(input int ep);
        tok_in = 1; tok_ep = 4'(ep);
        tick();
    endtask

    task automatic check_word(input string req, input int ep, input int b, input int l,
                              input int r, input int p);
        rd_ep = 4'(ep);
        #1;
        chk({req, " rd_bid"},  rd_bid,  b);
        chk({req, " rd_len"},  rd_len,  l);
        chk({req, " rd_rdy"},  rd_rdy,  r);
        chk({req, " rd_pend"}, rd_pend, p);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        idle();
        rd_ep = 0;
        ctrl_ep = 12'h001;
        stall = '0;
        rst = 1;
        @(negedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 sent", sent, 0);
        chk("R1 irq", irq, 0);
        chk("R1 resp", resp, 0);
        rst = 0;
        @(negedge clk);

        // Table walk: R2 R3 R4 R5 R6 R7 R9 R10
        for (int i = 0; i < NVEC; i++) begin
            case (TBL[i].op)
                OP_WR: begin
                    cfg_wr = 1; cfg_ep = TBL[i].ep; cfg_bid = TBL[i].bid;
                    cfg_len = TBL[i].len; cfg_rdy = TBL[i].rdy;
                end
                OP_IN:    begin tok_in = 1; tok_ep = TBL[i].ep; end
                OP_ACK:   host_ack = 1;
                OP_SETUP: begin tok_setup = 1; tok_ep = TBL[i].ep; end
                default:  sent_clr = TBL[i].mask;
            endcase
            tick();
            chk($sformatf("R3/R4 vec%0d resp", i), resp, TBL[i].eresp);
            if (TBL[i].eresp == 2'd1) begin
                chk($sformatf("R6 vec%0d resp_bid", i), resp_bid, TBL[i].ebid);
                chk($sformatf("R6 vec%0d resp_len", i), resp_len, TBL[i].elen);
            end
            chk($sformatf("R5/R7 vec%0d sent", i), sent, TBL[i].esent);
            check_word($sformatf("R2/R9/R10 vec%0d", i), TBL[i].ep, TBL[i].ebid,
                       TBL[i].elen, TBL[i].erdy, TBL[i].epend);
        end

        // R4: stall beats a ready slot; ACK after stall is ignored (R5)
        stall = 12'h002;
        in_tok(1);
        chk("R4 stall resp", resp, 3);
        host_ack = 1;
        tick();
        chk("R5 ack after stall sent", sent, 12'h020);
        check_word("R4 stall keeps slot", 1, 4, 0, 1, 0);
        stall = '0;

        // R8: ACK and clear on the same bit
        in_tok(1);
        chk("R8 data resp", resp, 1);
        host_ack = 1; sent_clr = 12'h002;
        tick();
        chk("R8 ack beats clear", sent, 12'h022);
        chk("R7 irq high", irq, 1);

        // R11: software write and ACK on the same endpoint
        wr(3, 9, 10, 1);
        in_tok(3);
        chk("R11 data resp_bid", resp_bid, 9);
        host_ack = 1;
        cfg_wr = 1; cfg_ep = 4'd3; cfg_bid = 5'd12; cfg_len = 7'd5; cfg_rdy = 1;
        tick();
        chk("R11 sent", sent, 12'h02A);
        check_word("R11 written value kept", 3, 12, 5, 1, 0);

        // R7: clear all completion bits drops the interrupt
        sent_clr = 12'hFFF;
        tick();
        chk("R7 sent cleared", sent, 0);
        chk("R7 irq low", irq, 0);

        // R1: reset in mid-run clears the slots
        rst = 1;
        tick();
        rst = 0;
        check_word("R1 slot after reset", 3, 0, 0, 0, 0);
        chk("R1 resp after reset", resp, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule